// File: doc/BRIEF.md
# Asynchronous memory controller

This block runs single read and write accesses on an external asynchronous memory bus, such as SRAM or NOR flash. Requests come from an internal valid/ready port that carries the address, byte enables, write data and direction. Each access has three phases: setup, strobe and hold. Their lengths, in clock cycles, are set separately for reads and writes on static configuration inputs. A programmable turnaround gap follows every access. During the strobe, the output enable (reads) or write enable (writes) is low. Chip enable either covers all three phases or, in select-strobe mode, follows the strobe exactly.

An optional extended-wait mode lets an external WAIT pin hold the strobe open. The pin passes through a two-flop synchronizer, and its active level is selectable. The strobe ends a fixed number of clock edges after WAIT goes inactive. A cap, counted in units of 16 cycles, bounds the wait. When the cap is hit, the access finishes anyway and a timeout pulse is raised. Read data is captured on the last strobe cycle and returned with a one-cycle valid pulse.

Top module: `async_mem_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, mem_ce_no, mem_oe_no and mem_we_no are 1, mem_dq_oe_o, rsp_valid_o and timeout_o are 0, and req_ready_o is 1.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. The first setup cycle is the cycle right after that edge.
- R3: Each timing field encodes its length minus one: setup 4 bits (1..16), strobe 6 bits (1..64), hold 3 bits (1..8), turnaround 2 bits (1..4). With extended wait off, a read gives S setup cycles, then mem_oe_no low for exactly ST cycles, then H hold cycles. In normal mode, mem_ce_no is low for exactly S+ST+H cycles, starting in the first setup cycle.
- R4: A write follows R3 using the write fields and mem_we_no in place of mem_oe_no. During it, mem_oe_no stays 1, and mem_dq_o carries the write data with mem_dq_oe_o at 1 throughout the strobe.
- R5: With cfg_sel_strobe_i at 1, mem_ce_no is low in exactly the strobe cycles, with no setup or hold offset.
- R6: After the hold phase come T turnaround cycles with every strobe and chip enable inactive. req_ready_o rises in the last of them, so a waiting request starts its setup after exactly T idle cycles.
- R7: For a read, rsp_rdata_o returns mem_dq_i as sampled at the edge that ends the last strobe cycle. rsp_valid_o is high for exactly one cycle, the first hold cycle. Writes produce no rsp_valid_o.
- R8: mem_addr_o and mem_be_no (the active-low form of req_be_i) hold the request's values in every cycle that mem_ce_no is low.
- R9: With cfg_ext_wait_i at 0, the WAIT pin has no effect on the strobe length.
- R10: With extended wait on, the WAIT level captured at the edge that ends strobe cycle j (counting from 0) extends the strobe only if j <= ST-6. A WAIT already active during setup extends any strobe of 4 or more cycles. An extension holds the strobe low while WAIT stays active.
- R11: After an honoured WAIT goes inactive on the pin, the strobe rises at the fourth clock edge after that pin change.
- R12: If WAIT stays active, the extension lasts (M+1)*16 cycles, where M is the 8-bit cfg_max_wait_i. The strobe then ends, and timeout_o pulses for exactly one cycle in the first hold cycle, alongside rsp_valid_o for a read.
- R13: cfg_wait_pol_i at 1 makes a high WAIT pin active. At 0, a low pin is active and a high pin is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_rd_setup_i | input | 4 | Read setup cycles minus one |
| cfg_rd_strobe_i | input | 6 | Read strobe cycles minus one |
| cfg_rd_hold_i | input | 3 | Read hold cycles minus one |
| cfg_wr_setup_i | input | 4 | Write setup cycles minus one |
| cfg_wr_strobe_i | input | 6 | Write strobe cycles minus one |
| cfg_wr_hold_i | input | 3 | Write hold cycles minus one |
| cfg_turn_i | input | 2 | Turnaround cycles minus one |
| cfg_sel_strobe_i | input | 1 | Chip enable follows the strobe |
| cfg_ext_wait_i | input | 1 | Enable strobe extension from WAIT |
| cfg_wait_pol_i | input | 1 | 1: WAIT active high, 0: active low |
| cfg_max_wait_i | input | 8 | Wait cap in 16-cycle units minus one |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when valid |
| req_we_i | input | 1 | 1: write, 0: read |
| req_addr_i | input | AW | Request address |
| req_be_i | input | BW | Byte enables, active high |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DW | Read data |
| timeout_o | output | 1 | Wait cap reached, one-cycle pulse |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_be_no | output | BW | Byte enables, active low |
| mem_dq_o | output | DW | Write data to the pads |
| mem_dq_i | input | DW | Read data from the pads |
| mem_dq_oe_o | output | 1 | Data pad drive enable |
| mem_wait_i | input | 1 | External WAIT pin |

## Verification
All results are placed on a cycle index that starts at 0 in the first setup cycle after acceptance:
- **Strobe and chip enable:** the strobe starts at index S.
- **Read response:** rsp_valid_o and timeout_o are due at index S+ST, plus any extension.
- **Ready:** req_ready_o is due at S+ST+H+T-1.

The bench drives mem_dq_i to a new value derived from the index in every cycle, so the returned word shows which edge captured it. WAIT is driven on chosen indices. The release is checked as exactly three cycles between the pin change and the last strobe cycle. The bench samples every output at the falling edge and compares the recorded first index, last index and count of each result against these formulas.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } amc_phase_e;

  // strobe cycles that must still follow the cycle in which wait is first seen
  localparam int unsigned WAIT_LEAD       = 3;
  localparam int unsigned WAIT_GRAIN_LOG2 = 4;
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic pol_i,
  output logic wait_act_o
);
  logic [STAGES-1:0] sq;
  logic              act_raw;

  // polarity folded in before the first flop so reset means inactive
  assign act_raw = ~(wait_i ^ pol_i);

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= act_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[STAGES-2:0], act_raw};
      end
    end
  endgenerate

  assign wait_act_o = sq[STAGES-1];
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int unsigned SETUP_W  = 4,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 3,
  parameter int unsigned TURN_W   = 2,
  parameter int unsigned MAXW_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  output logic                ready_o,
  output logic                start_o,
  input  logic [SETUP_W-1:0]  cfg_rd_setup_i,
  input  logic [STROBE_W-1:0] cfg_rd_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_rd_hold_i,
  input  logic [SETUP_W-1:0]  cfg_wr_setup_i,
  input  logic [STROBE_W-1:0] cfg_wr_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_wr_hold_i,
  input  logic [TURN_W-1:0]   cfg_turn_i,
  input  logic                cfg_ext_wait_i,
  input  logic [MAXW_W-1:0]   cfg_max_wait_i,
  input  logic                wait_act_i,
  output amc_phase_e          phase_o,
  output logic                op_we_o,
  output logic                strobe_end_o,
  output logic                timeout_o
);
  localparam int unsigned CW_A = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int unsigned CW_B = (HOLD_W > TURN_W) ? HOLD_W : TURN_W;
  localparam int unsigned CW   = (CW_A > CW_B) ? CW_A : CW_B;
  localparam int unsigned WCW  = MAXW_W + WAIT_GRAIN_LOG2;

  amc_phase_e     ph_q;
  logic [CW-1:0]  cnt_q;
  logic [WCW-1:0] wcnt_q;
  logic           op_we_q, wt_q, tmo_q;

  logic [CW-1:0]  setup_ld, strobe_ld, hold_ld, turn_ld;
  logic [WCW-1:0] wait_lim;
  logic           honor, tmo_hit, cnt_zero;

  always_comb begin
    cnt_zero     = (cnt_q == '0);
    ready_o      = (ph_q == PH_IDLE) || (ph_q == PH_TURN && cnt_zero);
    start_o      = req_valid_i && ready_o;
    setup_ld     = req_we_i ? CW'(cfg_wr_setup_i) : CW'(cfg_rd_setup_i);
    strobe_ld    = op_we_q ? CW'(cfg_wr_strobe_i) : CW'(cfg_rd_strobe_i);
    hold_ld      = op_we_q ? CW'(cfg_wr_hold_i) : CW'(cfg_rd_hold_i);
    turn_ld      = CW'(cfg_turn_i);
    wait_lim     = {cfg_max_wait_i, {WAIT_GRAIN_LOG2{1'b1}}};
    honor        = cfg_ext_wait_i && wait_act_i && !wt_q && (cnt_q >= CW'(WAIT_LEAD));
    tmo_hit      = wt_q && wait_act_i && (wcnt_q == wait_lim);
    strobe_end_o = (ph_q == PH_STROBE) && (wt_q ? tmo_hit : (!honor && cnt_zero));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      op_we_q <= 1'b0;
      wt_q    <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_o) begin
            ph_q    <= PH_SETUP;
            cnt_q   <= setup_ld;
            op_we_q <= req_we_i;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            ph_q  <= PH_STROBE;
            cnt_q <= strobe_ld;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        PH_STROBE: begin
          if (wt_q) begin
            if (!wait_act_i) begin
              // one more strobe cycle: ends four edges after the pin change
              wt_q  <= 1'b0;
              cnt_q <= '0;
            end else if (tmo_hit) begin
              wt_q  <= 1'b0;
              tmo_q <= 1'b1;
              ph_q  <= PH_HOLD;
              cnt_q <= hold_ld;
            end else begin
              wcnt_q <= wcnt_q + WCW'(1);
            end
          end else if (honor) begin
            wt_q   <= 1'b1;
            wcnt_q <= '0;
          end else if (cnt_zero) begin
            ph_q  <= PH_HOLD;
            cnt_q <= hold_ld;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            ph_q  <= PH_TURN;
            cnt_q <= turn_ld;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        PH_TURN: begin
          if (cnt_zero) begin
            if (start_o) begin
              ph_q    <= PH_SETUP;
              cnt_q   <= setup_ld;
              op_we_q <= req_we_i;
            end else begin
              ph_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = ph_q;
  assign op_we_o   = op_we_q;
  assign timeout_o = tmo_q;

  a_r2_ready_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ph_q == PH_IDLE || ph_q == PH_TURN));
  a_r3_setup_enters_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SETUP && cnt_zero) |=> (ph_q == PH_STROBE));
  a_r9_no_ext_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ext_wait_i && ph_q == PH_STROBE) |=> !wt_q);
  a_r11_release_last_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wt_q && !wait_act_i) |=> (ph_q == PH_STROBE && cnt_zero && !wt_q));
  a_r12_timeout_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> !tmo_q);
  a_r12_wait_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_q |-> (wcnt_q <= wait_lim));
endmodule

// File: rtl/amc_pins.sv
module amc_pins
  import amc_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [BW-1:0] req_be_i,
  input  logic [DW-1:0] req_wdata_i,
  input  amc_phase_e    phase_i,
  input  logic          op_we_i,
  input  logic          strobe_end_i,
  input  logic          sel_strobe_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_be_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;
  logic          busy, stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (start_i) begin
        addr_q  <= req_addr_i;
        be_q    <= req_be_i;
        wdata_q <= req_wdata_i;
      end
      rsp_q <= strobe_end_i && !op_we_i;
      if (strobe_end_i && !op_we_i) rdata_q <= mem_dq_i;
    end
  end

  always_comb begin
    busy        = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
    stb         = (phase_i == PH_STROBE);
    mem_ce_no   = sel_strobe_i ? !stb : !busy;
    mem_oe_no   = !(stb && !op_we_i);
    mem_we_no   = !(stb && op_we_i);
    mem_dq_oe_o = busy && op_we_i;
  end

  assign mem_addr_o  = addr_q;
  assign mem_be_no   = ~be_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  a_r5_strobe_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_ce_no);
  a_r6_turn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TURN) |-> (mem_ce_no && mem_oe_no && mem_we_no && !mem_dq_oe_o));
  a_r7_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r8_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> ($stable(mem_addr_o) && $stable(mem_be_no)));
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned AW          = 20,
  parameter int unsigned DW          = 16,
  parameter int unsigned BW          = DW / 8,
  parameter int unsigned SETUP_W     = 4,
  parameter int unsigned STROBE_W    = 6,
  parameter int unsigned HOLD_W      = 3,
  parameter int unsigned TURN_W      = 2,
  parameter int unsigned MAXW_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SETUP_W-1:0]  cfg_rd_setup_i,
  input  logic [STROBE_W-1:0] cfg_rd_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_rd_hold_i,
  input  logic [SETUP_W-1:0]  cfg_wr_setup_i,
  input  logic [STROBE_W-1:0] cfg_wr_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_wr_hold_i,
  input  logic [TURN_W-1:0]   cfg_turn_i,
  input  logic                cfg_sel_strobe_i,
  input  logic                cfg_ext_wait_i,
  input  logic                cfg_wait_pol_i,
  input  logic [MAXW_W-1:0]   cfg_max_wait_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [BW-1:0]       req_be_i,
  input  logic [DW-1:0]       req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DW-1:0]       rsp_rdata_o,
  output logic                timeout_o,
  output logic                mem_ce_no,
  output logic                mem_oe_no,
  output logic                mem_we_no,
  output logic [AW-1:0]       mem_addr_o,
  output logic [BW-1:0]       mem_be_no,
  output logic [DW-1:0]       mem_dq_o,
  input  logic [DW-1:0]       mem_dq_i,
  output logic                mem_dq_oe_o,
  input  logic                mem_wait_i
);
  logic       wait_act, start, op_we, strobe_end;
  amc_phase_e phase;

  amc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_i     (mem_wait_i),
    .pol_i      (cfg_wait_pol_i),
    .wait_act_o (wait_act)
  );

  amc_seq #(
    .SETUP_W (SETUP_W),
    .STROBE_W(STROBE_W),
    .HOLD_W  (HOLD_W),
    .TURN_W  (TURN_W),
    .MAXW_W  (MAXW_W)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_we_i       (req_we_i),
    .ready_o        (req_ready_o),
    .start_o        (start),
    .cfg_rd_setup_i (cfg_rd_setup_i),
    .cfg_rd_strobe_i(cfg_rd_strobe_i),
    .cfg_rd_hold_i  (cfg_rd_hold_i),
    .cfg_wr_setup_i (cfg_wr_setup_i),
    .cfg_wr_strobe_i(cfg_wr_strobe_i),
    .cfg_wr_hold_i  (cfg_wr_hold_i),
    .cfg_turn_i     (cfg_turn_i),
    .cfg_ext_wait_i (cfg_ext_wait_i),
    .cfg_max_wait_i (cfg_max_wait_i),
    .wait_act_i     (wait_act),
    .phase_o        (phase),
    .op_we_o        (op_we),
    .strobe_end_o   (strobe_end),
    .timeout_o      (timeout_o)
  );

  amc_pins #(.AW(AW), .DW(DW), .BW(BW)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .phase_i     (phase),
    .op_we_i     (op_we),
    .strobe_end_i(strobe_end),
    .sel_strobe_i(cfg_sel_strobe_i),
    .mem_dq_i    (mem_dq_i),
    .mem_ce_no   (mem_ce_no),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no),
    .mem_addr_o  (mem_addr_o),
    .mem_be_no   (mem_be_no),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: tb/sim_async_mem_ctrl.sv
module sim_async_mem_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam logic [DW-1:0] RD_BASE = 16'h5A3C;
  localparam int MAX_IDX = 400;

  // {we, setup-1[3:0], strobe-1[5:0], hold-1[2:0], turn-1[1:0], sel}
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 4'd0,  6'd0,  3'd0, 2'd0, 1'b0},
    {1'b0, 4'd15, 6'd63, 3'd7, 2'd3, 1'b0},
    {1'b1, 4'd2,  6'd4,  3'd1, 2'd1, 1'b0},
    {1'b0, 4'd3,  6'd2,  3'd2, 2'd2, 1'b1},
    {1'b1, 4'd0,  6'd0,  3'd0, 2'd0, 1'b1},
    {1'b1, 4'd15, 6'd63, 3'd7, 2'd3, 1'b1},
    {1'b0, 4'd5,  6'd9,  3'd3, 2'd1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] c_setup = '0;
  logic [5:0] c_strobe = '0;
  logic [2:0] c_hold = '0;
  logic [1:0] c_turn = '0;
  logic c_sel = 1'b0, c_ext = 1'b0, c_pol = 1'b1;
  logic [7:0] c_maxw = '0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] dq_in = '0;
  logic wait_pin = 1'b0;
  logic req_ready, rsp_valid, tmo, ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] be_n;

  int total = 0, bad = 0;
  int ce_first, ce_last, ce_cnt, oe_first, oe_last, oe_cnt, we_first, we_cnt;
  int rsp_idx, rsp_cnt, tmo_idx, tmo_cnt, ready_idx, addr_bad, dq_bad;
  logic [DW-1:0] rsp_data;
  int w_on = -1, w_off = -1;

  always #2.5 clk = ~clk;

  async_mem_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_rd_setup_i(c_setup), .cfg_rd_strobe_i(c_strobe), .cfg_rd_hold_i(c_hold),
    .cfg_wr_setup_i(c_setup), .cfg_wr_strobe_i(c_strobe), .cfg_wr_hold_i(c_hold),
    .cfg_turn_i(c_turn), .cfg_sel_strobe_i(c_sel), .cfg_ext_wait_i(c_ext),
    .cfg_wait_pol_i(c_pol), .cfg_max_wait_i(c_maxw),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .timeout_o(tmo),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_addr_o(mem_addr),
    .mem_be_no(be_n), .mem_dq_o(dq_out), .mem_dq_i(dq_in), .mem_dq_oe_o(dq_oe),
    .mem_wait_i(wait_pin)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where ready is seen
  task automatic run_acc(input logic we, input logic [AW-1:0] a, input logic [BW-1:0] be,
                         input logic [DW-1:0] d);
    ce_first = -1; ce_last = -1; ce_cnt = 0; oe_first = -1; oe_last = -1; oe_cnt = 0;
    we_first = -1; we_cnt = 0; rsp_idx = -1; rsp_cnt = 0; tmo_idx = -1; tmo_cnt = 0;
    ready_idx = -1; addr_bad = 0; dq_bad = 0; rsp_data = '0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int idx = 0; idx < MAX_IDX; idx++) begin
      dq_in = RD_BASE ^ 16'(idx);
      if (idx == w_on)  wait_pin = c_pol;
      if (idx == w_off) wait_pin = ~c_pol;
      if (!ce_n) begin
        if (ce_first < 0) ce_first = idx;
        ce_last = idx; ce_cnt++;
        if (mem_addr != a || be_n != ~be) addr_bad++;
      end
      if (!oe_n) begin
        if (oe_first < 0) oe_first = idx;
        oe_last = idx; oe_cnt++;
      end
      if (!we_n) begin
        if (we_first < 0) we_first = idx;
        we_cnt++;
        if (dq_out != d || !dq_oe) dq_bad++;
      end
      if (rsp_valid) begin rsp_idx = idx; rsp_cnt++; rsp_data = rsp_rdata; end
      if (tmo) begin tmo_idx = idx; tmo_cnt++; end
      if (req_ready) begin ready_idx = idx; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs under reset
    chk("R1 ce_n in reset", ce_n, 1);
    chk("R1 oe_n/we_n in reset", {oe_n, we_n}, 3);
    chk("R1 rsp/tmo/dq_oe in reset", {rsp_valid, tmo, dq_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {ce_n, oe_n, we_n, req_ready, rsp_valid, tmo, dq_oe}, 7'b1111000);
    chk("R2 ready while idle", req_ready, 1);

    for (int i = 0; i < 7; i++) begin
      logic we;
      int s, st, h, t;
      logic [DW-1:0] wd;
      we = VEC[i][16];
      c_setup = VEC[i][15:12]; c_strobe = VEC[i][11:6]; c_hold = VEC[i][5:3];
      c_turn = VEC[i][2:1]; c_sel = VEC[i][0];
      s = int'(c_setup) + 1; st = int'(c_strobe) + 1; h = int'(c_hold) + 1; t = int'(c_turn) + 1;
      wd = 16'hA500 ^ 16'(i * 37);
      run_acc(we, 20'h1_0000 + 20'(i * 273), 2'(i + 1), wd);
      if (c_sel) begin
        chk("R5 ce first", ce_first, s);
        chk("R5 ce count", ce_cnt, st);
      end else begin
        chk("R2 R3 ce first", ce_first, 0);
        chk("R3 ce count", ce_cnt, s + st + h);
      end
      if (we) begin
        chk("R4 we first", we_first, s);
        chk("R4 we count", we_cnt, st);
        chk("R4 oe idle on write", oe_cnt, 0);
        chk("R4 write data", dq_bad, 0);
        chk("R7 no rsp on write", rsp_cnt, 0);
      end else begin
        chk("R3 oe first", oe_first, s);
        chk("R3 oe count", oe_cnt, st);
        chk("R3 we idle on read", we_cnt, 0);
        chk("R7 rsp index", rsp_idx, s + st);
        chk("R7 rsp count", rsp_cnt, 1);
        chk("R7 rsp data", int'(rsp_data), int'(RD_BASE ^ 16'(s + st - 1)));
      end
      chk("R8 addr/be held", addr_bad, 0);
      chk("R6 ready index", ready_idx, s + st + h + t - 1);
    end

    // extended wait: setup 2, strobe 8, hold 2, turn 1
    c_setup = 4'd1; c_strobe = 6'd7; c_hold = 3'd1; c_turn = 2'd0; c_sel = 1'b0;
    c_ext = 1'b1; c_pol = 1'b1; c_maxw = 8'd3; wait_pin = 1'b0;

    w_on = 0; w_off = 20;
    run_acc(1'b0, 20'h0_0ABC, 2'b11, '0);
    chk("R11 release edge count", oe_last - 20, 3);
    chk("R10 extended strobe", oe_cnt, 22);
    chk("R7 data after release", int'(rsp_data), int'(RD_BASE ^ 16'(23)));
    chk("R12 no timeout", tmo_cnt, 0);
    wait_pin = 1'b0;

    w_on = 5; w_off = -1;
    run_acc(1'b0, 20'h0_0ABD, 2'b01, '0);
    chk("R10 late wait ignored", oe_cnt, 8);
    wait_pin = 1'b0;

    w_on = 4; w_off = 10;
    run_acc(1'b0, 20'h0_0ABE, 2'b10, '0);
    chk("R10 boundary wait honoured", oe_cnt, 12);
    chk("R11 boundary release", oe_last, 13);
    wait_pin = 1'b0;

    c_maxw = 8'd0; w_on = 0; w_off = -1;
    run_acc(1'b0, 20'h0_0AC0, 2'b11, '0);
    chk("R12 capped strobe", oe_cnt, 17);
    chk("R12 timeout index", tmo_idx, 19);
    chk("R12 timeout pulse", tmo_cnt, 1);
    chk("R12 rsp with timeout", rsp_idx, 19);
    wait_pin = 1'b0;

    w_on = 0; w_off = -1;
    run_acc(1'b1, 20'h0_0AC1, 2'b11, 16'h1234);
    chk("R12 write capped", we_cnt, 17);
    chk("R12 write timeout", tmo_cnt, 1);
    wait_pin = 1'b0;

    c_ext = 1'b0; w_on = 0; w_off = -1;
    run_acc(1'b0, 20'h0_0AC2, 2'b11, '0);
    chk("R9 wait ignored when off", oe_cnt, 8);
    chk("R9 no timeout when off", tmo_cnt, 0);
    wait_pin = 1'b0;

    c_ext = 1'b1; c_pol = 1'b0; wait_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    w_on = -1; w_off = -1;
    run_acc(1'b0, 20'h0_0AC3, 2'b11, '0);
    chk("R13 high pin inactive when active-low", oe_cnt, 8);
    w_on = 0;
    run_acc(1'b0, 20'h0_0AC4, 2'b11, '0);
    chk("R13 low pin active when active-low", oe_cnt, 17);
    wait_pin = 1'b1;

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule